// File: doc/BRIEF.md
# Accumulator Integer Execute Unit

This unit performs the integer work of a small 32-bit processor. It covers accumulator arithmetic, in-place register updates, three-operand bitwise logic and half-word literal inserts. The decoder has already read the register file. It hands the unit a byte-wide opcode, up to two source values, a destination index and a 16-bit literal, and holds `op_valid` high for one cycle per instruction.

One clock edge after an instruction is accepted, the unit presents a register-file write request, or a one-cycle illegal-instruction pulse. It also updates its internal accumulator and the three compare flags that a branch unit reads. Instructions may arrive back to back.

For the in-place instructions (increment, decrement, shifts and literal inserts), the decoder supplies the current value of the named register on source A. It places that register's index on the destination index.

Top module: `acc_exec_unit`

## Requirements
- R1: Opcode 0x08 loads the accumulator with accumulator + A, and opcode 0x09 loads it with accumulator − A, both modulo 2^W. Neither requests a register write. Every other opcode leaves the accumulator unchanged.
- R2: Opcode 0x0A writes A+1 to the destination, and 0x0B writes A−1. Both wrap modulo 2^W.
- R3: Opcode 0x0C writes A shifted left by one bit, with bit 0 set to zero.
- R4: Opcode 0x0D writes A shifted right by one bit, with the top bit set to zero.
- R5: Opcodes 0x0E, 0x0F, 0x11, 0x12, 0x13 and 0x14 write A AND B, A OR B, A XOR B, NOT(A AND B), NOT(A OR B) and NOT(A XOR B) respectively.
- R6: Opcode 0x10 writes the bitwise inverse of A, and B has no effect on the result.
- R7: Opcode 0x23 writes {literal, A[15:0]}, and opcode 0x24 writes {A[31:16], literal}. The half that is not replaced keeps its value from A.
- R8: On opcodes 0x08 and 0x09, the flags record a signed comparison of the accumulator value before the operation with A. The flags are equal (acc = A), greater (acc > A) and less (acc < A). Exactly one flag is set at all times, and all other opcodes hold the flags.
- R9: Any opcode outside 0x08–0x14, 0x23 and 0x24 raises `illegal` for one cycle. Such an opcode requests no write and leaves the accumulator and flags unchanged.
- R10: Results appear on the cycle after `op_valid`, with the write index equal to the destination index. When `op_valid` is low, the next cycle has no write and no illegal pulse.
- R11: After reset the accumulator is zero, no write or illegal pulse is present, and only the equal flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Instruction opcode byte |
| src_a | input | W | First source value |
| src_b | input | W | Second source value |
| dst_idx | input | IW | Destination register index |
| literal | input | W/2 | Literal half-word |
| wr_en | output | 1 | Register write request |
| wr_idx | output | IW | Register write index |
| wr_data | output | W | Register write value |
| acc | output | W | Accumulator value |
| flag_eq | output | 1 | Equal flag |
| flag_gt | output | 1 | Signed greater-than flag |
| flag_lt | output | 1 | Signed less-than flag |
| illegal | output | 1 | Unrecognised opcode pulse |

## Verification
A corrupted accumulator becomes visible on the `acc` port in the cycle after the faulty update. It also skews the flags on the next add or subtract, so a running model of the accumulator catches it at the first arithmetic instruction. A bad flag update shows at once, either as a zero-hot or multi-hot flag set or as a mismatch against the signed compare of the previous accumulator value. A faulty decode shows on the next cycle as a write that should not happen, a missing illegal pulse, or a wrong value on `wr_data`.

// File: rtl/acc_exec_unit.sv
module acc_exec_unit #(
  parameter int W  = 32,
  parameter int IW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [7:0]      opcode,
  input  logic [W-1:0]    src_a,
  input  logic [W-1:0]    src_b,
  input  logic [IW-1:0]   dst_idx,
  input  logic [W/2-1:0]  literal,
  output logic            wr_en,
  output logic [IW-1:0]   wr_idx,
  output logic [W-1:0]    wr_data,
  output logic [W-1:0]    acc,
  output logic            flag_eq,
  output logic            flag_gt,
  output logic            flag_lt,
  output logic            illegal
);
  localparam int HW = W / 2;

  logic [W-1:0] res;
  logic         legal, writes, arith;

  always_comb begin
    res    = '0;
    legal  = 1'b1;
    writes = 1'b1;
    arith  = 1'b0;
    unique case (opcode)
      8'h08, 8'h09: begin writes = 1'b0; arith = 1'b1; end
      8'h0A: res = src_a + 1'b1;
      8'h0B: res = src_a - 1'b1;
      8'h0C: res = {src_a[W-2:0], 1'b0};
      8'h0D: res = {1'b0, src_a[W-1:1]};
      8'h0E: res = src_a & src_b;
      8'h0F: res = src_a | src_b;
      8'h10: res = ~src_a;
      8'h11: res = src_a ^ src_b;
      8'h12: res = ~(src_a & src_b);
      8'h13: res = ~(src_a | src_b);
      8'h14: res = ~(src_a ^ src_b);
      8'h23: res = {literal, src_a[HW-1:0]};
      8'h24: res = {src_a[W-1:HW], literal};
      default: begin legal = 1'b0; writes = 1'b0; end
    endcase
  end

  wire signed [W-1:0] acc_s = acc;
  wire signed [W-1:0] a_s   = src_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      flag_eq <= 1'b1;
      flag_gt <= 1'b0;
      flag_lt <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      illegal <= 1'b0;
    end else begin
      wr_en   <= op_valid && writes;
      illegal <= op_valid && !legal;
      if (op_valid && writes) begin
        wr_idx  <= dst_idx;
        wr_data <= res;
      end
      if (op_valid && arith) begin
        acc     <= opcode[0] ? acc - src_a : acc + src_a;
        flag_eq <= acc_s == a_s;
        flag_gt <= acc_s >  a_s;
        flag_lt <= acc_s <  a_s;
      end
    end
  end

  AST_FLAGS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({flag_eq, flag_gt, flag_lt}) == 1); // R8
  AST_ILL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wr_en); // R9
  AST_ACC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode != 8'h08 && opcode != 8'h09) |=> acc == $past(acc)); // R1
  AST_SHR_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 8'h0D) |=> (wr_en && !wr_data[W-1])); // R4
  AST_UPPER_INSERT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 8'h23) |=> wr_data[HW-1:0] == $past(src_a[HW-1:0])); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!wr_en && !illegal)); // R10
endmodule

// File: tb/sim_acc_exec_unit.sv
module sim_acc_exec_unit;
  localparam int PERIOD = 10;
  localparam int W = 32;
  localparam int IW = 4;

  logic clk = 0, rst_n = 0, op_valid = 0;
  logic [7:0] opcode = 0;
  logic [W-1:0] src_a = 0, src_b = 0;
  logic [IW-1:0] dst_idx = 0;
  logic [W/2-1:0] literal = 0;
  logic wr_en, flag_eq, flag_gt, flag_lt, illegal;
  logic [IW-1:0] wr_idx;
  logic [W-1:0] wr_data, acc;

  int total = 0, bad = 0;
  bit done = 0;
  logic [W-1:0] m_acc = 0;
  logic [2:0] m_flags = 3'b100;

  acc_exec_unit #(.W(W), .IW(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .src_a(src_a), .src_b(src_b), .dst_idx(dst_idx), .literal(literal),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .acc(acc),
    .flag_eq(flag_eq), .flag_gt(flag_gt), .flag_lt(flag_lt), .illegal(illegal));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] val(input int i);
    case (i % 8)
      0: val = 32'h0000_0000;
      1: val = 32'hFFFF_FFFF;
      2: val = 32'h8000_0000;
      3: val = 32'h7FFF_FFFF;
      default: val = 32'h9E37_79B9 * (i + 3) + 32'h0101_0101 * i;
    endcase
  endfunction

  function automatic logic is_legal(input logic [7:0] op);
    is_legal = (op >= 8'h08 && op <= 8'h14) || op == 8'h23 || op == 8'h24;
  endfunction

  function automatic logic [W-1:0] model(input logic [7:0] op, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic [15:0] l);
    case (op)
      8'h0A: model = a + 1;
      8'h0B: model = a - 1;
      8'h0C: model = a * 2;
      8'h0D: model = a / 2;
      8'h0E: model = a & b;
      8'h0F: model = a | b;
      8'h10: model = ~a;
      8'h11: model = a ^ b;
      8'h12: model = ~(a & b);
      8'h13: model = ~(a | b);
      8'h14: model = ~(a ^ b);
      8'h23: model = (W'(l) << 16) | (a & 32'h0000_FFFF);
      default: model = (a & 32'hFFFF_0000) | W'(l);
    endcase
  endfunction

  function automatic string tag(input logic [7:0] op);
    case (op)
      8'h0A, 8'h0B: tag = "R2";
      8'h0C: tag = "R3";
      8'h0D: tag = "R4";
      8'h10: tag = "R6";
      8'h23, 8'h24: tag = "R7";
      default: tag = "R5";
    endcase
  endfunction

  task automatic issue(input logic [7:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [IW-1:0] d, input logic [15:0] l);
    op_valid = 1; opcode = op; src_a = a; src_b = b; dst_idx = d; literal = l;
    @(negedge clk);
    op_valid = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    if (!done) begin done = 1; $display("test done: total=%0d bad=%0d", total, bad); end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(acc == 0, "R11 acc", acc, 0);
    chk({flag_eq, flag_gt, flag_lt} == 3'b100, "R11 flags", W'({flag_eq, flag_gt, flag_lt}), 3'b100);
    chk(!wr_en && !illegal, "R11 quiet", W'({wr_en, illegal}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!wr_en && !illegal, "R10 idle", W'({wr_en, illegal}), 0);

    for (int op = 8'h0A; op <= 8'h24; op++) begin
      if (!is_legal(8'(op))) continue;
      for (int i = 0; i < 16; i++) begin
        logic [W-1:0] a, b, e;
        logic [15:0] l;
        a = val(i); b = val(15 - i + op); l = 16'(i * 16'h1111 + op);
        e = model(8'(op), a, b, l);
        issue(8'(op), a, b, IW'(i), l);
        chk(wr_en && !illegal, {tag(8'(op)), " R10 write"}, W'({wr_en, illegal}), 2'b10);
        chk(wr_data == e, tag(8'(op)), wr_data, e);
        chk(wr_idx == IW'(i), "R10 idx", W'(wr_idx), W'(i));
        chk(acc == m_acc, "R1 acc held", acc, m_acc);
      end
    end
    issue(8'h10, 32'h1234_5678, 32'h0, 4'd3, 16'h0);
    chk(wr_data == 32'hEDCB_A987, "R6 b zero", wr_data, 32'hEDCB_A987);

    for (int i = 0; i < 40; i++) begin
      logic [7:0] op;
      logic [W-1:0] a;
      op = (i % 3 == 2) ? 8'h09 : 8'h08;
      a = (i % 5 == 4) ? m_acc : val(i * 7 + 1);
      m_flags = {m_acc == a, $signed(m_acc) > $signed(a), $signed(m_acc) < $signed(a)};
      m_acc = op[0] ? m_acc - a : m_acc + a;
      issue(op, a, ~a, 4'd0, 16'h0);
      chk(acc == m_acc, "R1 acc", acc, m_acc);
      chk(!wr_en && !illegal, "R1 no write", W'({wr_en, illegal}), 0);
      chk({flag_eq, flag_gt, flag_lt} == m_flags, "R8 flags", W'({flag_eq, flag_gt, flag_lt}), W'(m_flags));
    end

    for (int op = 0; op < 256; op++) begin
      if (is_legal(8'(op))) continue;
      issue(8'(op), val(op), val(op + 1), 4'd5, 16'hBEEF);
      chk(illegal && !wr_en, "R9 pulse", W'({illegal, wr_en}), 2'b10);
      chk(acc == m_acc, "R9 acc", acc, m_acc);
      chk({flag_eq, flag_gt, flag_lt} == m_flags, "R9 flags", W'({flag_eq, flag_gt, flag_lt}), W'(m_flags));
    end
    @(negedge clk);
    chk(!illegal && !wr_en, "R9 one cycle", W'({illegal, wr_en}), 0);

    issue(8'h0B, 32'h0, 32'h0, 4'd9, 16'h0);
    chk(wr_data == 32'hFFFF_FFFF, "R2 wrap", wr_data, 32'hFFFF_FFFF);
    issue(8'h0A, 32'hFFFF_FFFF, 32'h0, 4'd9, 16'h0);
    chk(wr_data == 32'h0, "R2 wrap up", wr_data, 0);

    if (!done) begin done = 1; $display("test done: total=%0d bad=%0d", total, bad); end
    $finish;
  end
endmodule